// File: doc/BRIEF.md
# Two-Page Coefficient FIR Filter

A parameterized signed FIR filter that computes y[n] = sum over k of c[k]·x[n-k] at full precision. The coefficients live in two pages. One page, the active page, drives a single serial multiply-accumulate engine. The other page, the auxiliary page, can be rewritten while filtering goes on. A new set becomes active through a swap command. The swap only takes effect between output samples, so the tap set never changes in the middle of a pass.

A build-time mode selects how the auxiliary page is refilled:
- **Streaming mode**: after a refresh pulse, coefficients arrive one per cycle on a valid-qualified port.
- **Preset mode**: after a refresh pulse, the block copies one of sixteen computed constant sets, chosen by a 4-bit selector.
- **Fixed mode**: the block holds a single constant set and takes no commands.

The sample port uses a valid/ready handshake. The block accepts one sample, spends TAPS cycles on the products, and then raises a one-cycle result strobe.

Top module: `dbfir_filter`

## Requirements
- R1: `dout` is signed and DW+CW+clog2(TAPS) bits wide (18 bits at defaults). It carries the exact sum of c[k]·x[n-k] for k = 0..TAPS-1 with no rounding or wrap. With every sample and every coefficient at the most negative value, the defaults give +65536.
- R2: A sample is taken only on an edge where `din_valid` and `din_ready` are both high. `din_ready` is low in the cycle after an acceptance. Samples offered while `din_ready` is low change neither the history nor any result.
- R3: For a sample accepted on edge E, `dout_valid` is low through edge E+TAPS-1. It is high for exactly one cycle after edge E+TAPS, and `din_ready` is high again in that same cycle.
- R4: The history holds the TAPS most recent accepted samples, and the oldest is discarded first. x[n] (the newest) meets tap 0. After reset the history is all zero, so an impulse returns the taps in order 0, 1, 2, and so on.
- R5: After reset, both pages hold preset set 0, `din_ready` is high, and `dout`, `dout_valid` and `refresh_done` are zero.
- R6: In streaming mode, a `coef_refresh` pulse clears `refresh_done` and restarts the write index. Each following cycle with `coef_valid` high writes `coef_in` into auxiliary tap 0, 1, 2, and so on. `refresh_done` rises in the cycle after the TAPS-th write. Further `coef_valid` cycles are ignored until the next refresh.
- R7: In preset mode, a `coef_refresh` pulse captures `coef_set_sel` = s. The block then writes auxiliary tap k with C(s,k) = (s+1)·(k+1) − 4, one tap per cycle. `refresh_done` rises TAPS cycles after the refresh edge.
- R8: `refresh_done` stays high until a later refresh or an applied swap clears it. Filtering does not clear it, and until a swap the auxiliary page has no effect on results.
- R9: A `coef_swap` pulse exchanges the two pages. It is applied at the first edge on which the engine is idle. A swap received during a pass waits until that result is out, so every result uses a single page.
- R10: In fixed mode, set 0 is always used, `refresh_done` stays low, and refresh, swap and coefficient inputs have no effect.
- R11: Holding `srst_n` low at a clock edge restores the R5 state, the same as `arst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| arst_n | input | 1 | Asynchronous reset, active low, release synchronized inside |
| srst_n | input | 1 | Synchronous reset, active low |
| din | input | DW | Signed sample |
| din_valid | input | 1 | Sample offered |
| din_ready | output | 1 | Engine idle, sample can be taken |
| coef_in | input | CW | Signed streamed coefficient |
| coef_valid | input | 1 | `coef_in` carries a coefficient |
| coef_refresh | input | 1 | Start refilling the auxiliary page |
| coef_set_sel | input | SEL_W | Preset set index for preset mode |
| coef_swap | input | 1 | Exchange active and auxiliary pages |
| refresh_done | output | 1 | Auxiliary page completely filled |
| dout | output | DW+CW+clog2(TAPS) | Signed full-precision result |
| dout_valid | output | 1 | One-cycle result strobe |

## Verification
The testbench runs three copies side by side, one per mode, on shared stimulus.
- An impulse into a zero history shows whether tap order and history direction are correct.
- Mixed-sign sample runs separate correct sign extension of products from wrong sign extension.
- All-most-negative samples and coefficients expose any truncation in the result width.
- Junk samples offered while busy separate a correct handshake from one that lets extra samples in.
- A swap raised in the middle of a pass separates deferred page exchange from immediate exchange: an immediate swap yields a result mixed from both sets.
- Streamed loads with a surplus coefficient, and preset copies with a nonzero selector, test write indexing and the flag that reports a full page.

// File: rtl/dbfir_pkg.sv
package dbfir_pkg;

  // Refill source of the auxiliary page
  typedef enum logic [1:0] {
    COEF_FIXED  = 2'd0,
    COEF_PRESET = 2'd1,
    COEF_STREAM = 2'd2
  } coef_mode_e;

  // Preset set s, tap k
  function automatic int preset_coef(input int set_idx, input int tap_idx);
    return (set_idx + 1) * (tap_idx + 1) - 4;
  endfunction

endpackage

// File: rtl/dbfir_rst_sync.sv
module dbfir_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/dbfir_coef_bank.sv
module dbfir_coef_bank
  import dbfir_pkg::*;
#(
  parameter int         CW    = 8,
  parameter int         TAPS  = 4,
  parameter int         SEL_W = 4,
  parameter coef_mode_e MODE  = COEF_STREAM
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     srst_n,
  input  logic [CW-1:0]            coef_in,
  input  logic                     coef_valid,
  input  logic                     refresh,
  input  logic [SEL_W-1:0]         set_sel,
  input  logic                     swap_req,
  input  logic                     swap_ok,
  output logic [TAPS-1:0][CW-1:0]  act_coef,
  output logic                     fill_done
);

  localparam int CNT_W = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TAPS - 1);

  typedef logic [TAPS-1:0][CW-1:0] page_t;

  function automatic page_t base_page();
    page_t p;
    for (int k = 0; k < TAPS; k++) p[k] = CW'(preset_coef(0, k));
    return p;
  endfunction

  localparam page_t BASE = base_page();

  logic [1:0][TAPS-1:0][CW-1:0] pg_q, pg_n;
  logic             act_q, act_n;
  logic             load_q, load_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [SEL_W-1:0] sel_q, sel_n;
  logic             done_q, done_n;
  logic             pend_q, pend_n;

  logic             wr_ok;
  logic [CW-1:0]    wr_val;
  logic             ref_go;
  logic             swap_go;
  logic             pg_we;

  // Refill source picked by mode
  generate
    if (MODE == COEF_STREAM) begin : g_stream
      logic unused_stream;
      assign unused_stream = ^sel_q;
      assign wr_ok   = coef_valid;
      assign wr_val  = coef_in;
      assign ref_go  = refresh;
      assign swap_go = swap_req;
    end else if (MODE == COEF_PRESET) begin : g_preset
      logic unused_preset;
      assign unused_preset = ^{coef_in, coef_valid};
      assign wr_ok   = 1'b1;
      assign wr_val  = CW'(preset_coef(int'(sel_q), int'(cnt_q)));
      assign ref_go  = refresh;
      assign swap_go = swap_req;
    end else begin : g_fixed
      logic unused_fixed;
      assign unused_fixed = ^{coef_in, coef_valid, refresh, swap_req, sel_q, cnt_q};
      assign wr_ok   = 1'b0;
      assign wr_val  = '0;
      assign ref_go  = 1'b0;
      assign swap_go = 1'b0;
    end
  endgenerate

  always_comb begin
    pg_n   = pg_q;
    act_n  = act_q;
    load_n = load_q;
    cnt_n  = cnt_q;
    sel_n  = sel_q;
    done_n = done_q;
    pend_n = pend_q | swap_go;
    if (ref_go) begin
      load_n = 1'b1;
      cnt_n  = '0;
      done_n = 1'b0;
      sel_n  = set_sel;
    end else if (load_q && wr_ok) begin
      pg_n[!act_q][cnt_q] = wr_val;
      if (cnt_q == LAST) begin
        load_n = 1'b0;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
    if (pend_n && swap_ok) begin
      act_n  = !act_q;
      pend_n = 1'b0;
      done_n = 1'b0;
    end
    if (!srst_n) begin
      pg_n   = {BASE, BASE};
      act_n  = 1'b0;
      load_n = 1'b0;
      cnt_n  = '0;
      sel_n  = '0;
      done_n = 1'b0;
      pend_n = 1'b0;
    end
  end

  assign pg_we = (load_q & wr_ok) | !srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q   <= {BASE, BASE};
      act_q  <= 1'b0;
      load_q <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= '0;
      done_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (pg_we) pg_q <= pg_n;
      act_q  <= act_n;
      load_q <= load_n;
      cnt_q  <= cnt_n;
      sel_q  <= sel_n;
      done_q <= done_n;
      pend_q <= pend_n;
    end
  end

  assign act_coef  = pg_q[act_q];
  assign fill_done = done_q;

endmodule

// File: rtl/dbfir_mac.sv
module dbfir_mac #(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int TAPS = 4,
  parameter int OW   = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    srst_n,
  input  logic [DW-1:0]           din,
  input  logic                    din_valid,
  input  logic [TAPS-1:0][CW-1:0] coefs,
  output logic                    ready,
  output logic [OW-1:0]           dout,
  output logic                    dout_valid
);

  localparam int IDX_W = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int PW    = DW + CW;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TAPS - 1);

  logic                    busy_q, busy_n;
  logic [IDX_W-1:0]        idx_q, idx_n;
  logic signed [OW-1:0]    acc_q, acc_n;
  logic [TAPS-1:0][DW-1:0] line_q, line_n;
  logic [OW-1:0]           out_q, out_n;
  logic                    vld_q, vld_n;
  logic                    line_we;

  logic signed [PW-1:0]    x_ext, c_ext, prod;
  logic signed [OW-1:0]    sum;

  assign x_ext = PW'($signed(line_q[idx_q]));
  assign c_ext = PW'($signed(coefs[idx_q]));
  assign prod  = x_ext * c_ext;
  assign sum   = acc_q + OW'(prod);

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    acc_n  = acc_q;
    line_n = line_q;
    out_n  = out_q;
    vld_n  = 1'b0;
    if (busy_q) begin
      if (idx_q == LAST) begin
        out_n  = sum;
        vld_n  = 1'b1;
        busy_n = 1'b0;
      end else begin
        acc_n = sum;
        idx_n = idx_q + 1'b1;
      end
    end else if (din_valid) begin
      line_n = {line_q[TAPS-2:0], din};
      busy_n = 1'b1;
      idx_n  = '0;
      acc_n  = '0;
    end
    if (!srst_n) begin
      busy_n = 1'b0;
      idx_n  = '0;
      acc_n  = '0;
      line_n = '0;
      out_n  = '0;
      vld_n  = 1'b0;
    end
  end

  assign line_we = (!busy_q & din_valid) | !srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
      line_q <= '0;
      out_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (line_we) line_q <= line_n;
      busy_q <= busy_n;
      idx_q  <= idx_n;
      acc_q  <= acc_n;
      out_q  <= out_n;
      vld_q  <= vld_n;
    end
  end

  assign ready      = !busy_q;
  assign dout       = out_q;
  assign dout_valid = vld_q;

endmodule

// File: rtl/dbfir_filter.sv
module dbfir_filter
  import dbfir_pkg::*;
#(
  parameter int         DW    = 8,
  parameter int         CW    = 8,
  parameter int         TAPS  = 4,
  parameter int         SEL_W = 4,
  parameter coef_mode_e MODE  = COEF_STREAM
) (
  input  logic                              clk,
  input  logic                              arst_n,
  input  logic                              srst_n,
  input  logic [DW-1:0]                     din,
  input  logic                              din_valid,
  output logic                              din_ready,
  input  logic [CW-1:0]                     coef_in,
  input  logic                              coef_valid,
  input  logic                              coef_refresh,
  input  logic [SEL_W-1:0]                  coef_set_sel,
  input  logic                              coef_swap,
  output logic                              refresh_done,
  output logic [DW+CW+$clog2(TAPS)-1:0]     dout,
  output logic                              dout_valid
);

  localparam int OW = DW + CW + $clog2(TAPS);

  logic                    rst_n_sync;
  logic [TAPS-1:0][CW-1:0] act_coef;

  dbfir_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n_sync)
  );

  dbfir_coef_bank #(
    .CW    (CW),
    .TAPS  (TAPS),
    .SEL_W (SEL_W),
    .MODE  (MODE)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .srst_n     (srst_n),
    .coef_in    (coef_in),
    .coef_valid (coef_valid),
    .refresh    (coef_refresh),
    .set_sel    (coef_set_sel),
    .swap_req   (coef_swap),
    .swap_ok    (din_ready),
    .act_coef   (act_coef),
    .fill_done  (refresh_done)
  );

  dbfir_mac #(
    .DW   (DW),
    .CW   (CW),
    .TAPS (TAPS),
    .OW   (OW)
  ) u_mac (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .srst_n     (srst_n),
    .din        (din),
    .din_valid  (din_valid),
    .coefs      (act_coef),
    .ready      (din_ready),
    .dout       (dout),
    .dout_valid (dout_valid)
  );

endmodule

// File: rtl/dbfir_chk.sv
module dbfir_chk
  import dbfir_pkg::*;
#(
  parameter int         CW   = 8,
  parameter int         TAPS = 4,
  parameter coef_mode_e MODE = COEF_STREAM
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    srst_n,
  input logic                    din_valid,
  input logic                    din_ready,
  input logic                    dout_valid,
  input logic                    coef_refresh,
  input logic                    refresh_done,
  input logic [TAPS-1:0][CW-1:0] act_coef
);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    (din_valid && din_ready) |=> !din_ready);

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    dout_valid |=> !dout_valid);

  // R3
  strobe_after_pass_chk: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    dout_valid |-> $past(!din_ready));

  // R9
  coef_steady_chk: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    (!din_ready && $past(!din_ready)) |-> $stable(act_coef));

  // R6
  refresh_clears_chk: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    (MODE != COEF_FIXED && coef_refresh) |=> !refresh_done);

  // R10
  fixed_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    (MODE == COEF_FIXED) |-> !refresh_done);

  // R10
  fixed_coef_chk: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    (MODE == COEF_FIXED) |-> $stable(act_coef));

endmodule

bind dbfir_filter dbfir_chk #(
  .CW   (CW),
  .TAPS (TAPS),
  .MODE (MODE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .srst_n       (srst_n),
  .din_valid    (din_valid),
  .din_ready    (din_ready),
  .dout_valid   (dout_valid),
  .coef_refresh (coef_refresh),
  .refresh_done (refresh_done),
  .act_coef     (act_coef)
);

// File: tb/sim_dbfir_filter.sv
`timescale 1ns/1ps
module sim_dbfir_filter;
  import dbfir_pkg::*;

  localparam int DW = 8, CW = 8, TAPS = 4, SEL_W = 4;
  localparam int OW = DW + CW + $clog2(TAPS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic arst_n, srst_n, din_valid, coef_valid, coef_refresh, coef_swap;
  logic [DW-1:0]    din;
  logic [CW-1:0]    coef_in;
  logic [SEL_W-1:0] coef_set_sel;
  logic             rdy [3];
  logic             done [3];
  logic             vld [3];
  logic [OW-1:0]    dout [3];

  dbfir_filter #(.DW(DW), .CW(CW), .TAPS(TAPS), .SEL_W(SEL_W), .MODE(COEF_STREAM)) u0 (
    .clk(clk), .arst_n(arst_n), .srst_n(srst_n), .din(din), .din_valid(din_valid),
    .din_ready(rdy[0]), .coef_in(coef_in), .coef_valid(coef_valid), .coef_refresh(coef_refresh),
    .coef_set_sel(coef_set_sel), .coef_swap(coef_swap), .refresh_done(done[0]),
    .dout(dout[0]), .dout_valid(vld[0]));
  dbfir_filter #(.DW(DW), .CW(CW), .TAPS(TAPS), .SEL_W(SEL_W), .MODE(COEF_PRESET)) u1 (
    .clk(clk), .arst_n(arst_n), .srst_n(srst_n), .din(din), .din_valid(din_valid),
    .din_ready(rdy[1]), .coef_in(coef_in), .coef_valid(coef_valid), .coef_refresh(coef_refresh),
    .coef_set_sel(coef_set_sel), .coef_swap(coef_swap), .refresh_done(done[1]),
    .dout(dout[1]), .dout_valid(vld[1]));
  dbfir_filter #(.DW(DW), .CW(CW), .TAPS(TAPS), .SEL_W(SEL_W), .MODE(COEF_FIXED)) u2 (
    .clk(clk), .arst_n(arst_n), .srst_n(srst_n), .din(din), .din_valid(din_valid),
    .din_ready(rdy[2]), .coef_in(coef_in), .coef_valid(coef_valid), .coef_refresh(coef_refresh),
    .coef_set_sel(coef_set_sel), .coef_swap(coef_swap), .refresh_done(done[2]),
    .dout(dout[2]), .dout_valid(vld[2]));

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  int act_m [3][TAPS];
  int aux_m [3][TAPS];
  int hist [TAPS];
  longint q0 [$];
  longint q1 [$];
  longint q2 [$];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int pc(input int s, input int k);
    return (s + 1) * (k + 1) - 4;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++)
      for (int k = 0; k < TAPS; k++) begin
        act_m[i][k] = pc(0, k);
        aux_m[i][k] = pc(0, k);
      end
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
  endtask

  task automatic model_swap();
    for (int i = 0; i < 2; i++)
      for (int k = 0; k < TAPS; k++) begin
        int t;
        t = act_m[i][k];
        act_m[i][k] = aux_m[i][k];
        aux_m[i][k] = t;
      end
  endtask

  function automatic longint expect_of(input int i);
    longint s = 0;
    for (int k = 0; k < TAPS; k++) s += longint'(act_m[i][k]) * longint'(hist[k]);
    return s;
  endfunction

  // Driver: pushes expected results into the scoreboard queues
  task automatic send(input int x, input bit poke, input bit swap_mid);
    while (!rdy[0]) @(negedge clk);
    din = DW'(x);
    din_valid = 1'b1;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    q0.push_back(expect_of(0));
    q1.push_back(expect_of(1));
    q2.push_back(expect_of(2));
    @(negedge clk);
    din_valid = poke;
    if (poke) din = 8'h55;
    if (swap_mid) begin
      coef_swap = 1'b1;
      model_swap();
    end
    chk("R2", "ready low after accept", rdy[0], 0);
    for (int c = 1; c <= TAPS; c++) begin
      @(negedge clk);
      din_valid = 1'b0;
      coef_swap = 1'b0;
      if (c < TAPS) chk("R3", "no strobe before pass ends", vld[0], 0);
    end
    chk("R3", "strobe after TAPS edges", vld[0], 1);
    chk("R3", "ready back with strobe", rdy[0], 1);
  endtask

  task automatic load(input int c [TAPS], input int sel);
    coef_set_sel = SEL_W'(sel);
    coef_refresh = 1'b1;
    @(negedge clk);
    coef_refresh = 1'b0;
    for (int k = 0; k < TAPS; k++) begin
      coef_valid = 1'b1;
      coef_in = CW'(c[k]);
      chk("R6", "stream done low while filling", done[0], 0);
      chk("R7", "preset done low while copying", done[1], 0);
      @(negedge clk);
    end
    chk("R6", "stream done after last write", done[0], 1);
    chk("R7", "preset done after TAPS cycles", done[1], 1);
    chk("R10", "fixed mode done stays low", done[2], 0);
    coef_in = 8'h7F;
    @(negedge clk);
    coef_valid = 1'b0;
    for (int k = 0; k < TAPS; k++) begin
      aux_m[0][k] = c[k];
      aux_m[1][k] = pc(sel, k);
    end
  endtask

  task automatic swap_idle();
    coef_swap = 1'b1;
    @(negedge clk);
    coef_swap = 1'b0;
    model_swap();
    chk("R8", "stream done cleared by swap", done[0], 0);
    chk("R8", "preset done cleared by swap", done[1], 0);
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (arst_n && srst_n) begin
      for (int i = 0; i < 3; i++) begin
        if (vld[i]) begin
          longint e;
          bit have;
          have = 0;
          e = 0;
          case (i)
            0: if (q0.size() > 0) begin e = q0.pop_front(); have = 1; end
            1: if (q1.size() > 0) begin e = q1.pop_front(); have = 1; end
            default: if (q2.size() > 0) begin e = q2.pop_front(); have = 1; end
          endcase
          n_chk++;
          if (!have) begin
            n_fail++;
            $display("FAIL R1 unexpected result inst=%0d actual=%0d expected=none", i,
                     longint'($signed(dout[i])));
          end else if (longint'($signed(dout[i])) !== e) begin
            n_fail++;
            $display("FAIL R1 result inst=%0d actual=%0d expected=%0d", i,
                     longint'($signed(dout[i])), e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    arst_n = 0; srst_n = 1; din = '0; din_valid = 0; coef_in = '0; coef_valid = 0;
    coef_refresh = 0; coef_set_sel = '0; coef_swap = 0;
    model_reset();
    repeat (3) @(negedge clk);
    arst_n = 1;
    repeat (3) @(negedge clk);

    // R5 reset state
    for (int i = 0; i < 3; i++) begin
      chk("R5", "ready after reset", rdy[i], 1);
      chk("R5", "strobe after reset", vld[i], 0);
      chk("R5", "dout after reset", dout[i], 0);
      chk("R5", "done after reset", done[i], 0);
    end
    chk("R1", "output width", $bits(dout[0]), 18);

    // R4 impulse reveals tap order of set 0
    send(1, 0, 0); send(0, 0, 0); send(0, 0, 0); send(0, 0, 0);
    // R1 mixed signs, R2 junk offered while busy
    send(3, 0, 0); send(-5, 1, 0); send(7, 1, 0); send(2, 0, 0); send(100, 0, 0);

    // R6/R7 refill; R8 aux inactive until swap, done held
    load('{10, -20, 30, -40}, 5);
    send(-9, 0, 0);
    chk("R8", "done held across filtering", done[0], 1);
    swap_idle();
    send(1, 0, 0); send(0, 0, 0); send(-3, 0, 0); send(50, 0, 0);

    // R9 swap raised mid-pass is deferred
    send(20, 0, 1);
    send(-7, 0, 0); send(4, 0, 0);

    // R1 full precision extreme
    load('{-128, -128, -128, -128}, 15);
    swap_idle();
    for (int j = 0; j < TAPS; j++) send(-128, 0, 0);

    // R11 synchronous reset
    @(negedge clk);
    srst_n = 0;
    @(negedge clk);
    srst_n = 1;
    model_reset();
    for (int i = 0; i < 3; i++) begin
      chk("R11", "ready after sync reset", rdy[i], 1);
      chk("R11", "dout after sync reset", dout[i], 0);
      chk("R11", "done after sync reset", done[i], 0);
    end
    send(1, 0, 0); send(0, 0, 0); send(2, 0, 0);

    repeat (3) @(negedge clk);
    chk("R1", "scoreboard drained u0", q0.size(), 0);
    chk("R1", "scoreboard drained u1", q1.size(), 0);
    chk("R10", "scoreboard drained fixed", q2.size(), 0);
    finish_run();
  end

endmodule